// File: doc/BRIEF.md
# Vector Doubleword Multiply-Sum Unit

This execution unit works on three 128-bit vector operands, each made of two unsigned 64-bit doublewords. It forms the full 128-bit product of the two high-order doublewords of operands A and B, and the full 128-bit product of their two low-order doublewords. Each product can be doubled on its own mask bit. The unit then adds both products to operand C, taken as one 128-bit number, and returns the 128-bit sum with no carry-out.

A request is one cycle of `start` with the operands, an element-size code and a 4-bit control mask. Only the doubleword size code is legal. Any other code sets an error flag and leaves the result as it was. The unit multiplies iteratively, a digit of `DIG_W` bits per cycle, and reports completion with a one-cycle `done` pulse. `result` and `err` stay valid until the next accepted request.

Top module: `vmsum_unit`

## Requirements
- R1: A size code other than 3 sets `err`, gives a `done` pulse in the cycle right after the start edge, and leaves `result` unchanged.
- R2: In every operand and in `result`, bits [127:64] are the even, high-order element and bits [63:0] are the odd, low-order element.
- R3: The even product is the unsigned 128-bit product of A[127:64] and B[127:64]. The odd product is the unsigned 128-bit product of A[63:0] and B[63:0].
- R4: With `mask` bit 3 (value 8) set, the even product is shifted left by one bit inside 128 bits, and the bit shifted out is lost.
- R5: With `mask` bit 2 (value 4) set, the odd product is doubled the same way, independently of bit 3.
- R6: `mask` bits 1 and 0 have no effect on `result`.
- R7: `result` equals even product plus odd product plus C, modulo 2^128.
- R8: After a legal start edge, `done` is high for exactly one cycle, beginning 64/DIG_W+1 rising edges later. `result` changes only at that point.
- R9: A `start` that arrives while the unit is busy is ignored. It does not alter the running operation, the result or the error flag, and it produces no extra `done`.
- R10: After reset, `result` is zero, `done` and `err` are low, and the unit is idle.
- R11: An accepted legal request clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| size_code | input | 4 | Element-size code; 3 is doubleword |
| mask | input | 4 | Bit 3 doubles the even product, bit 2 doubles the odd product |
| opa | input | 128 | Multiplicand vector |
| opb | input | 128 | Multiplier vector |
| opc | input | 128 | 128-bit addend |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Specification error from the last accepted request |
| result | output | 128 | 128-bit sum |

## Verification
With the default DIG_W of 16, a legal request finishes `done` five rising edges after the edge that samples `start`. An illegal size code finishes one edge after it. The bench drives `start` on a falling edge and counts falling edges until `done` is seen. It checks that count against 6 or 1 exactly. Only on that falling edge does it compare `result` and `err` with its own reference. Busy-time pulses are placed on the second and third falling edges, which fall inside the multiply phase.

// File: rtl/vmsum_pkg.sv
package vmsum_pkg;
  localparam int unsigned DW = 64;
  localparam int unsigned VW = 2 * DW;
  localparam logic [3:0]  SIZE_DWORD = 4'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUM  = 2'd2
  } vms_state_e;

  function automatic logic [VW-1:0] twice(input logic [VW-1:0] v, input logic en);
    return en ? {v[VW-2:0], 1'b0} : v;
  endfunction
endpackage

// File: rtl/vmsum_ctrl.sv
module vmsum_ctrl
  import vmsum_pkg::*;
#(
  parameter int unsigned STEPS = 4,
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic size_ok,
  output logic idle,
  output logic load,
  output logic step,
  output logic capture,
  output logic done,
  output logic err
);
  vms_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic done_q, done_d, err_q, err_d, accept;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  always_comb begin
    accept  = start && (state_q == ST_IDLE);
    load    = accept && size_ok;
    step    = (state_q == ST_RUN);
    capture = (state_q == ST_SUM);
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (load) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        if (cnt_q == LAST) state_d = ST_SUM;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_SUM:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    done_d = capture || (accept && !size_ok);
    err_d  = accept ? !size_ok : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign idle = (state_q == ST_IDLE);
  assign done = done_q;
  assign err  = err_q;

  assert_run_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != LAST) |=> step);
  assert_sum_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (done_q && !capture && !step));
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && start) |=> (err_q == $past(err_q)));
  assert_err_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> done_q);
endmodule

// File: rtl/vmsum_mul.sv
module vmsum_mul
  import vmsum_pkg::*;
#(
  parameter int unsigned DIG_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] mcand,
  input  logic [DW-1:0] mplier,
  output logic [VW-1:0] prod
);
  logic [VW-1:0] acc_q, acc_d, partial;
  logic [DW-1:0] mc_q, mc_d, mp_q, mp_d;

  always_comb begin
    partial = VW'(mc_q) * VW'(mp_q[DW-1 -: DIG_W]);
    acc_d   = acc_q;
    mc_d    = mc_q;
    mp_d    = mp_q;
    if (load) begin
      acc_d = '0;
      mc_d  = mcand;
      mp_d  = mplier;
    end else if (step) begin
      acc_d = (acc_q << DIG_W) + partial;
      mp_d  = mp_q << DIG_W;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
    end else if (load || step) begin
      acc_q <= acc_d;
      mc_q  <= mc_d;
      mp_q  <= mp_d;
    end
  end

  assign prod = acc_q;

  assert_load_step_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && step));
endmodule

// File: rtl/vmsum_combine.sv
module vmsum_combine
  import vmsum_pkg::*;
(
  input  logic [VW-1:0] prod_even,
  input  logic [VW-1:0] prod_odd,
  input  logic [1:0]    dbl,
  input  logic [VW-1:0] addend,
  output logic [VW-1:0] sum
);
  logic [VW-1:0] lane [2];
  logic [VW-1:0] src  [2];

  assign src[0] = prod_even;
  assign src[1] = prod_odd;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane[g] = twice(src[g], dbl[g]);
  end

  assign sum = lane[0] + lane[1] + addend;
endmodule

// File: rtl/vmsum_unit.sv
module vmsum_unit
  import vmsum_pkg::*;
#(
  parameter int unsigned DIG_W = 16,
  localparam int unsigned STEPS = DW / DIG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    size_code,
  input  logic [3:0]    mask,
  input  logic [VW-1:0] opa,
  input  logic [VW-1:0] opb,
  input  logic [VW-1:0] opc,
  output logic          done,
  output logic          err,
  output logic [VW-1:0] result
);
  logic [1:0] rsync_q;
  logic rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic idle, load, step, capture, size_ok;
  assign size_ok = (size_code == SIZE_DWORD);

  vmsum_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .start(start), .size_ok(size_ok),
    .idle(idle), .load(load), .step(step), .capture(capture),
    .done(done), .err(err)
  );

  logic [VW-1:0] c_q;
  logic [1:0]    dbl_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q   <= '0;
      dbl_q <= '0;
    end else if (load) begin
      c_q   <= opc;
      dbl_q <= {mask[2], mask[3]};
    end
  end

  logic [VW-1:0] prod [2];

  for (genvar g = 0; g < 2; g++) begin : g_mul
    localparam int unsigned LO = (1 - g) * DW;
    vmsum_mul #(.DIG_W(DIG_W)) u_mul (
      .clk(clk), .rst_n(rst_ni), .load(load), .step(step),
      .mcand(opa[LO +: DW]), .mplier(opb[LO +: DW]), .prod(prod[g])
    );
  end

  logic [VW-1:0] sum;

  vmsum_combine u_comb (
    .prod_even(prod[0]), .prod_odd(prod[1]), .dbl(dbl_q),
    .addend(c_q), .sum(sum)
  );

  logic [VW-1:0] result_q, result_d;

  always_comb begin
    result_d = result_q;
    if (capture) result_d = sum;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) result_q <= '0;
    else if (capture) result_q <= result_d;
  end

  assign result = result_q;

  assert_bad_size_keep_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (idle && start && !size_ok) |=> (err && done && $stable(result_q)));
  assert_result_on_done_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (result_q != $past(result_q)) |-> (done && !err));
endmodule

// File: tb/tb_vmsum_unit.sv
`timescale 1ns/1ps
module tb_vmsum_unit;
  localparam int DIG_W = 16;
  localparam int LAT_OK = 64 / DIG_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] size_code = 4'd3;
  logic [3:0] mask = 4'd0;
  logic [127:0] opa = '0, opb = '0, opc = '0;
  logic done, err;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  logic [127:0] last_res = '0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vmsum_unit #(.DIG_W(DIG_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_code(size_code),
    .mask(mask), .opa(opa), .opb(opb), .opc(opc),
    .done(done), .err(err), .result(result)
  );

  function automatic logic [127:0] ref_sum(input logic [127:0] a, input logic [127:0] b,
                                           input logic [127:0] c, input logic [3:0] m);
    logic [127:0] pe, po;
    pe = {64'd0, a[127:64]} * {64'd0, b[127:64]};
    po = {64'd0, a[63:0]} * {64'd0, b[63:0]};
    if (m[3]) pe = pe << 1;
    if (m[2]) po = po << 1;
    return pe + po + c;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                        input logic [3:0] sz, input logic [3:0] m, input bit poke,
                        input string tag);
    int k;
    bit legal;
    logic [127:0] exp;
    legal = (sz == 4'd3);
    exp = legal ? ref_sum(a, b, c, m) : last_res;
    @(negedge clk);
    opa = a; opb = b; opc = c; size_code = sz; mask = m; start = 1'b1;
    k = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      k = i;
      start = poke && (i == 1 || i == 2);
      if (poke) begin
        opa = ~a; opb = a ^ b; opc = ~c; mask = ~m; size_code = 4'd3;
      end
      if (done) break;
    end
    start = 1'b0;
    check(k == (legal ? LAT_OK : 1), legal ? "R8 done latency" : "R1 error latency",
          128'(k), 128'(legal ? LAT_OK : 1));
    check(err == !legal, legal ? "R11 err cleared" : "R1 err set", 128'(err), 128'(!legal));
    check(result == exp, tag, result, exp);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", 128'(done), 128'd0);
    last_res = result;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(result == '0, "R10 reset result", result, '0);
    check(done == 1'b0, "R10 reset done", 128'(done), '0);
    check(err == 1'b0, "R10 reset err", 128'(err), '0);

    // R2/R3 plain products and element placement
    run_op({64'd3, 64'd5}, {64'd7, 64'd11}, '0, 4'd3, 4'd0, 1'b0, "R3 small products");
    run_op({64'd1, 64'd0}, {64'hFFFF_FFFF_FFFF_FFFF, 64'd9}, {64'd0, 64'd1}, 4'd3, 4'd0, 1'b0,
           "R2 element order");
    // R4/R5 every doubling combination, all-ones wraparound (R7)
    for (int m = 0; m < 4; m++) begin
      run_op('1, '1, '1, 4'd3, 4'(m << 2), 1'b0, "R7 all-ones wrap R4 R5");
      run_op({64'h8000_0000_0000_0001, 64'h1234_5678_9ABC_DEF0},
             {64'hFFFF_0000_FFFF_0000, 64'h0FED_CBA9_8765_4321},
             {64'hDEAD_BEEF_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF}, 4'd3, 4'(m << 2), 1'b0,
             "R4 R5 doubling combo");
    end
    // R6 low mask bits ignored
    run_op({64'h55, 64'hAA}, {64'h77, 64'h99}, {64'd4, 64'd8}, 4'd3, 4'b1011, 1'b0, "R6 low mask bits");
    run_op({64'h55, 64'hAA}, {64'h77, 64'h99}, {64'd4, 64'd8}, 4'd3, 4'b0111, 1'b0, "R6 low mask bits");
    // R1 illegal sizes keep result, R11 clears after
    run_op('1, '1, '1, 4'd2, 4'b1100, 1'b0, "R1 result kept");
    run_op('1, '1, '1, 4'd0, 4'b0000, 1'b0, "R1 result kept");
    run_op({64'd2, 64'd2}, {64'd2, 64'd2}, '0, 4'd3, 4'd0, 1'b0, "R11 legal after error");
    // R9 start pulses while busy
    run_op({64'd100, 64'd200}, {64'd300, 64'd400}, {64'd1, 64'd2}, 4'd3, 4'b1000, 1'b1,
           "R9 busy start ignored");
    begin
      bit extra = 1'b0;
      repeat (8) begin
        @(negedge clk);
        if (done) extra = 1'b1;
      end
      check(!extra, "R9 no extra done", 128'(extra), '0);
      check(result == last_res, "R9 result unchanged", result, last_res);
    end
    // Random mix
    for (int n = 0; n < 40; n++) begin
      logic [127:0] a, b, c;
      logic [3:0] sz, m;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      c = {$urandom, $urandom, $urandom, $urandom};
      m = 4'($urandom);
      sz = ($urandom % 5 == 0) ? 4'($urandom) : 4'd3;
      run_op(a, b, c, sz, m, 1'b0, "R7 random sum");
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule